// File: doc/BRIEF.md
# I2C Master Address-Phase Sequencer

This block drives the opening of an I2C master transfer at byte granularity. Software raises a START request and, separately, a STOP request. Both are set through one-cycle write strobes. Software also programs the target address, the addressing width (7-bit or 10-bit), the transfer direction and a read-header-only option. From these, the sequencer issues a stream of byte-level commands to a bit-level bus engine: START, RESTART, send-byte and STOP. The engine answers each command with a completion strobe. For byte sends, the engine also reports whether the byte was acknowledged.

The sequencer decides when a START may be launched. When it does not hold the bus, it waits for the bus to become free. When it already holds the bus, with automatic end disabled, it waits for the byte count to complete. A reload flag holds any launch back. In 10-bit mode it builds the header byte from the upper address bits. For a 10-bit read it inserts the repeated START and the read header. A NACK on the first 10-bit address byte causes the whole address sequence to be resent while the START request remains set. When the address phase ends, the block pulses a done strobe together with the acknowledge outcome. Hardware then clears the START request.

Top module: `i2c_addr_seq`

## Requirements
- R1: `sw_start_set` high for one cycle, with `enable` high and no clearing event, makes `start_req` read 1 from the next cycle. With `sw_start_set` low, `start_req` never rises.
- R2: `start_req` reads 0 in the cycle after any of the following: `addr_done`, `arb_lost`, `timeout`, `sw_start_clr`, or `enable` low. If one of these coincides with `sw_start_set`, the clear wins.
- R3: When `master_active` is 0, a pending START request issues a START command (`cmd_op`=0) only in the cycle after a cycle in which `bus_free` was 1. `master_active` becomes 1 when that START command completes.
- R4: When `master_active` is 1 and `auto_end` is 0, a pending START request waits for `count_done`. It then issues a RESTART command (`cmd_op`=1) followed by the address bytes.
- R5: While `reload` is 1, no START or RESTART is launched, and `start_req` stays set.
- R6: In 7-bit mode, exactly one send-byte command (`cmd_op`=2) follows the START. Its byte is {address[6:0], direction}, where direction is 0 for write and 1 for read.
- R7: A 10-bit write sends two bytes after the START. The first is the header {5'b11110, address[9:8], 0}. The second is address[7:0].
- R8: A 10-bit read with the header-only option off runs START, header(dir 0), address[7:0], RESTART, header(dir 1). The phase ends after the last header.
- R9: A 10-bit read with the header-only option on runs START, header(dir 1), and nothing more.
- R10: In 10-bit mode, a NACK on the first address byte while `start_req` is 1 resends the whole address sequence, starting with a RESTART. Any other address NACK ends the phase, with `addr_done` and `addr_nack` both 1.
- R11: `sw_stop_set` sets `stop_req`. `stop_req` clears in the cycle after `stop_seen` or `enable` low. When the sequencer is idle and `master_active` is 1, a set `stop_req` issues a STOP command (`cmd_op`=3).
- R12: A write through `cfg_wr` updates the address, width, direction and header-only settings only while `start_req` is 0. While `start_req` is 1, the write is ignored.
- R13: `cmd_valid` stays high with a stable command until `cmd_done`. `addr_done` is a single-cycle strobe. `cmd_valid` is 0 in the cycle after `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable; low clears requests and aborts |
| sw_start_set | input | 1 | Software write-1 strobe for the START request |
| sw_start_clr | input | 1 | Software clear strobe for the START request |
| sw_stop_set | input | 1 | Software write-1 strobe for the STOP request |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_hdr_only | input | 1 | 1 sends only the read header in a 10-bit read |
| cfg_read | input | 1 | Direction: 1 read, 0 write |
| cfg_addr | input | 10 | Target address |
| auto_end | input | 1 | Automatic end mode of the transfer |
| reload | input | 1 | Byte count reload pending |
| bus_free | input | 1 | Bus idle indication |
| count_done | input | 1 | Programmed byte count completed |
| arb_lost | input | 1 | Arbitration lost strobe |
| timeout | input | 1 | Timeout error strobe |
| cmd_done | input | 1 | Engine completed the current command |
| cmd_nack | input | 1 | Byte sent was not acknowledged (valid with cmd_done) |
| stop_seen | input | 1 | STOP condition detected on the bus |
| start_req | output | 1 | START request flag |
| stop_req | output | 1 | STOP request flag |
| master_active | output | 1 | Block currently owns the bus |
| cmd_valid | output | 1 | Command presented to the engine |
| cmd_op | output | 2 | 0 START, 1 RESTART, 2 send byte, 3 STOP |
| cmd_byte | output | 8 | Byte to send (0 for non-send commands) |
| addr_done | output | 1 | Address phase finished (strobe) |
| addr_nack | output | 1 | Address phase finished on a NACK (with addr_done) |

## Verification
The address width is fixed by the bus standard, so the bench builds the block with its package constants at their only values. An engine model in the bench answers each command after two cycles, and a queue supplies its acknowledge outcomes. This drives every path of the sequence: the plain 7-bit transfer, the 10-bit write, the full 10-bit read, the header-only read, the first-byte NACK retry and the late NACK. The bench can also hold the bus-free, count-done and reload inputs low or high for as long as needed. This exercises the launch conditions, and confirms that configuration writes are dropped while a request is pending.

// File: rtl/i2c_addr_seq_pkg.sv
`timescale 1ns/1ps
package i2c_addr_seq_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_SEND    = 2'd2,
    OP_STOP    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STOP, ST_COND, ST_B0, ST_B1, ST_RS, ST_B2
  } st_e;

  typedef struct packed {
    logic              ten;
    logic              hdr_only;
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cfg_t;

  // 10-bit header: fixed 11110 marker, upper address pair, direction
  function automatic logic [BYTE_W-1:0] ten_header(logic [ADDR_W-1:0] a, logic dir);
    return {5'b11110, a[ADDR_W-1:ADDR_W-2], dir};
  endfunction

  function automatic logic [BYTE_W-1:0] seven_byte(logic [ADDR_W-1:0] a, logic dir);
    return {a[6:0], dir};
  endfunction
endpackage

// File: rtl/asq_cfg.sv
`timescale 1ns/1ps
module asq_cfg
  import i2c_addr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic locked,
  input  cfg_t wdata,
  output cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             cfg_q <= '0;
    else if (wr && !locked) cfg_q <= wdata;
  end

  // R12: settings frozen while a START request is pending
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q));
endmodule

// File: rtl/asq_req.sv
`timescale 1ns/1ps
module asq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_set,
  input  logic start_clr,
  input  logic stop_set,
  input  logic phase_end,
  input  logic abort,
  input  logic stop_seen,
  output logic start_req,
  output logic stop_req
);
  logic start_kill, stop_kill;
  assign start_kill = !enable || phase_end || abort || start_clr;
  assign stop_kill  = !enable || stop_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_req <= 1'b0;
      stop_req  <= 1'b0;
    end else begin
      if (start_kill)     start_req <= 1'b0;
      else if (start_set) start_req <= 1'b1;
      if (stop_kill)      stop_req  <= 1'b0;
      else if (stop_set)  stop_req  <= 1'b1;
    end
  end

  p_start_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_set && !phase_end && !abort && !start_clr) |=> start_req);
  p_start_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req) |-> $past(start_set));
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end || abort || start_clr || !enable) |=> !start_req);
  p_stop_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen || !enable) |=> !stop_req);
endmodule

// File: rtl/asq_fsm.sv
`timescale 1ns/1ps
module asq_fsm
  import i2c_addr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              abort,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              auto_end,
  input  logic              reload,
  input  logic              bus_free,
  input  logic              count_done,
  input  logic              stop_seen,
  input  cfg_t              cfg,
  input  logic              cmd_done,
  input  logic              cmd_nack,
  output logic              cmd_valid,
  output op_e               cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              fin,
  output logic              fin_nack,
  output logic              master_act
);
  st_e  st, st_n;
  logic use_rs, use_rs_n;
  logic go, hdr_dir0, short_10;

  // launch condition: free bus when not owning it, count end when owning it
  assign go       = !reload && (master_act ? (!auto_end && count_done) : bus_free);
  assign short_10 = cfg.rd && cfg.hdr_only;
  assign hdr_dir0 = short_10;

  always_comb begin
    st_n     = st;
    use_rs_n = use_rs;
    fin      = 1'b0;
    fin_nack = 1'b0;
    case (st)
      ST_IDLE: begin
        if (stop_req && master_act) st_n = ST_STOP;
        else if (start_req && go) begin
          st_n     = ST_COND;
          use_rs_n = master_act;
        end
      end
      ST_STOP: if (cmd_done) st_n = ST_IDLE;
      ST_COND: if (cmd_done) st_n = ST_B0;
      ST_B0: if (cmd_done) begin
        if (cmd_nack) begin
          if (cfg.ten && start_req) begin
            st_n     = ST_COND;
            use_rs_n = 1'b1;
          end else begin
            st_n = ST_IDLE; fin = 1'b1; fin_nack = 1'b1;
          end
        end else if (!cfg.ten || short_10) begin
          st_n = ST_IDLE; fin = 1'b1;
        end else st_n = ST_B1;
      end
      ST_B1: if (cmd_done) begin
        if (cmd_nack) begin
          st_n = ST_IDLE; fin = 1'b1; fin_nack = 1'b1;
        end else if (cfg.rd) st_n = ST_RS;
        else begin
          st_n = ST_IDLE; fin = 1'b1;
        end
      end
      ST_RS: if (cmd_done) st_n = ST_B2;
      ST_B2: if (cmd_done) begin
        st_n = ST_IDLE; fin = 1'b1; fin_nack = cmd_nack;
      end
      default: st_n = ST_IDLE;
    endcase
    if (!enable || abort) begin
      st_n     = ST_IDLE;
      fin      = 1'b0;
      fin_nack = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      use_rs     <= 1'b0;
      master_act <= 1'b0;
    end else begin
      st     <= st_n;
      use_rs <= use_rs_n;
      if (!enable || abort || stop_seen)  master_act <= 1'b0;
      else if (st == ST_COND && cmd_done) master_act <= 1'b1;
    end
  end

  assign cmd_valid = (st != ST_IDLE);

  always_comb begin
    cmd_op   = OP_SEND;
    cmd_byte = '0;
    case (st)
      ST_STOP: cmd_op = OP_STOP;
      ST_COND: cmd_op = use_rs ? OP_RESTART : OP_START;
      ST_RS:   cmd_op = OP_RESTART;
      ST_B0:   cmd_byte = cfg.ten ? ten_header(cfg.addr, hdr_dir0) : seven_byte(cfg.addr, cfg.rd);
      ST_B1:   cmd_byte = cfg.addr[BYTE_W-1:0];
      ST_B2:   cmd_byte = ten_header(cfg.addr, 1'b1);
      default: ;
    endcase
  end

  p_start_after_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op == OP_START) |-> $past(bus_free));
  p_start_not_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_START) |-> !master_act);
  p_no_launch_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op != OP_STOP) |-> !$past(reload));
  p_hdr_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B2) |-> (cmd_byte[7:3] == 5'b11110 && cmd_byte[0]));
  p_hold_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done && enable && !abort) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));
  p_fin_then_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !cmd_valid);
  p_disable_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !cmd_valid);
endmodule

// File: rtl/i2c_addr_seq.sv
`timescale 1ns/1ps
module i2c_addr_seq
  import i2c_addr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sw_start_set,
  input  logic              sw_start_clr,
  input  logic              sw_stop_set,
  input  logic              cfg_wr,
  input  logic              cfg_ten_bit,
  input  logic              cfg_hdr_only,
  input  logic              cfg_read,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              auto_end,
  input  logic              reload,
  input  logic              bus_free,
  input  logic              count_done,
  input  logic              arb_lost,
  input  logic              timeout,
  input  logic              cmd_done,
  input  logic              cmd_nack,
  input  logic              stop_seen,
  output logic              start_req,
  output logic              stop_req,
  output logic              master_active,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              addr_done,
  output logic              addr_nack
);
  cfg_t cfg_w, cfg_q;
  op_e  op_w;
  logic abort_w, fin_w, fin_nack_w;

  assign cfg_w   = '{ten: cfg_ten_bit, hdr_only: cfg_hdr_only, rd: cfg_read, addr: cfg_addr};
  assign abort_w = arb_lost || timeout;

  asq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .locked(start_req),
    .wdata(cfg_w), .cfg_q(cfg_q)
  );

  asq_req u_req (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_set(sw_start_set), .start_clr(sw_start_clr), .stop_set(sw_stop_set),
    .phase_end(fin_w), .abort(abort_w), .stop_seen(stop_seen),
    .start_req(start_req), .stop_req(stop_req)
  );

  asq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .abort(abort_w),
    .start_req(start_req), .stop_req(stop_req),
    .auto_end(auto_end), .reload(reload), .bus_free(bus_free), .count_done(count_done),
    .stop_seen(stop_seen), .cfg(cfg_q), .cmd_done(cmd_done), .cmd_nack(cmd_nack),
    .cmd_valid(cmd_valid), .cmd_op(op_w), .cmd_byte(cmd_byte),
    .fin(fin_w), .fin_nack(fin_nack_w), .master_act(master_active)
  );

  assign cmd_op    = op_w;
  assign addr_done = fin_w;
  assign addr_nack = fin_nack_w;
endmodule

// File: tb/i2c_addr_seq_tb.sv
`timescale 1ns/1ps
module i2c_addr_seq_tb;
  logic clk = 0, rst_n = 0, enable = 0;
  logic sw_start_set = 0, sw_start_clr = 0, sw_stop_set = 0, cfg_wr = 0;
  logic cfg_ten_bit = 0, cfg_hdr_only = 0, cfg_read = 0;
  logic [9:0] cfg_addr = 0;
  logic auto_end = 1, reload = 0, bus_free = 1, count_done = 0;
  logic arb_lost = 0, timeout = 0, cmd_done = 0, cmd_nack = 0, stop_seen = 0;
  logic start_req, stop_req, master_active, cmd_valid, addr_done, addr_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  always #2 clk = ~clk;

  i2c_addr_seq u_dut (.*);

  int checks = 0, fails = 0;
  bit done_rep = 0;
  bit p_ss = 0, p_sc = 0, p_st = 0, p_cw = 0, p_arb = 0, p_to = 0;
  int eng_cnt = 0;
  bit nackq[$];
  logic [9:0] logq[$];
  bit saw_nack = 0;

  // ---------------- reference model ----------------
  bit m_start, m_stop, m_master, m_busy, m_stopping, m_first;
  bit m_ten, m_hdr, m_rd;
  logic [9:0] m_addr;
  logic [9:0] q[$];

  function automatic logic [7:0] hb(bit d);
    int v;
    v = 240 + 2 * int'(m_addr[9:8]) + (d ? 1 : 0);
    return v[7:0];
  endfunction

  function automatic void build(bit rs);
    q.delete();
    q.push_back({rs ? 2'd1 : 2'd0, 8'h00});
    if (!m_ten) q.push_back({2'd2, m_addr[6:0], m_rd});
    else if (m_rd && m_hdr) q.push_back({2'd2, hb(1)});
    else begin
      q.push_back({2'd2, hb(0)});
      q.push_back({2'd2, m_addr[7:0]});
      if (m_rd) begin
        q.push_back({2'd1, 8'h00});
        q.push_back({2'd2, hb(1)});
      end
    end
    m_first = 1;
  endfunction

  function automatic void mfin(output bit f, output bit fn);
    f = 0; fn = 0;
    if (!enable || arb_lost || timeout) return;
    if (m_busy && cmd_done && q.size() > 0 && q[0][9:8] == 2'd2) begin
      if (cmd_nack) begin
        if (!(m_first && m_ten && m_start)) begin f = 1; fn = 1; end
      end else if (q.size() == 1) f = 1;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_stop = 0; m_master = 0; m_busy = 0; m_stopping = 0; m_first = 0;
      m_ten = 0; m_hdr = 0; m_rd = 0; m_addr = 0; q.delete();
    end else begin
      bit f, fn, ab, cdone, go, retry;
      mfin(f, fn);
      ab = !enable || arb_lost || timeout;
      cdone = m_busy && cmd_done && q.size() > 0 && q[0][9:8] != 2'd2;
      retry = m_busy && cmd_done && q.size() > 0 && q[0][9:8] == 2'd2 && cmd_nack
              && m_first && m_ten && m_start && !ab;
      go = !reload && (m_master ? (!auto_end && count_done) : bus_free);
      if (cfg_wr && !m_start) begin
        m_ten = cfg_ten_bit; m_hdr = cfg_hdr_only; m_rd = cfg_read; m_addr = cfg_addr;
      end
      if (ab) begin m_busy = 0; m_stopping = 0; q.delete(); end
      else if (m_stopping) begin if (cmd_done) m_stopping = 0; end
      else if (m_busy) begin
        if (cmd_done) begin
          if (retry) build(1);
          else if (f) begin m_busy = 0; q.delete(); end
          else begin
            if (q[0][9:8] == 2'd2) m_first = 0;
            void'(q.pop_front());
          end
        end
      end else begin
        if (m_stop && m_master) m_stopping = 1;
        else if (m_start && go) begin build(m_master); m_busy = 1; end
      end
      if (ab || stop_seen) m_master = 0;
      else if (cdone) m_master = 1;
      if (!enable || f || arb_lost || timeout || sw_start_clr) m_start = 0;
      else if (sw_start_set) m_start = 1;
      if (!enable || stop_seen) m_stop = 0;
      else if (sw_stop_set) m_stop = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit f, fn, ev;
    mfin(f, fn);
    ev = m_busy || m_stopping;
    chk("R2", "start_req", start_req, m_start);
    chk("R11", "stop_req", stop_req, m_stop);
    chk("R3", "master_active", master_active, m_master);
    chk("R13", "cmd_valid", cmd_valid, ev);
    chk("R13", "addr_done", addr_done, f);
    chk("R10", "addr_nack", addr_nack, fn);
    if (ev) begin
      chk("R13", "cmd_op", cmd_op, m_stopping ? 2'd3 : q[0][9:8]);
      chk("R6", "cmd_byte", cmd_byte, m_stopping ? 8'h00 : q[0][7:0]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    sw_start_set = p_ss; sw_start_clr = p_sc; sw_stop_set = p_st;
    cfg_wr = p_cw; arb_lost = p_arb; timeout = p_to;
    p_ss = 0; p_sc = 0; p_st = 0; p_cw = 0; p_arb = 0; p_to = 0;
    cmd_done = 0; cmd_nack = 0; stop_seen = 0;
    if (cmd_valid) begin
      if (eng_cnt == 1) begin
        eng_cnt = 0;
        cmd_done = 1;
        if (cmd_op == 2'd2 && nackq.size() > 0) cmd_nack = nackq.pop_front();
        stop_seen = (cmd_op == 2'd3);
        logq.push_back({cmd_op, cmd_byte});
      end else eng_cnt++;
    end else eng_cnt = 0;
    #1;
    if (rst_n) compare();
    if (addr_done && addr_nack) saw_nack = 1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_cfg(bit ten, bit hdr, bit rd, logic [9:0] a);
    cfg_ten_bit = ten; cfg_hdr_only = hdr; cfg_read = rd; cfg_addr = a; p_cw = 1;
    tick();
  endtask

  task automatic chk_log(string req, logic [9:0] exp[$]);
    chk(req, "command count", logq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < logq.size(); i++)
      chk(req, "command", logq[i], exp[i]);
    logq.delete();
  endtask

  task automatic do_stop();
    p_st = 1; ticks(8);
    chk("R11", "stop command", logq.size() > 0 ? logq[0] : 10'h3ff, {2'd3, 8'h00});
    logq.delete();
    chk("R11", "master after stop", master_active, 0);
  endtask

  task automatic report();
    if (!done_rep) begin
      done_rep = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    ticks(3);
    rst_n = 1; enable = 1;
    tick();
    chk("R2", "reset start_req", start_req, 0);
    chk("R13", "reset cmd_valid", cmd_valid, 0);

    // R1: request rises only on the set strobe
    bus_free = 0;
    ticks(2);
    chk("R1", "no strobe", start_req, 0);
    p_ss = 1; tick(); tick();
    chk("R1", "after set", start_req, 1);
    p_sc = 1; ticks(2);
    chk("R2", "after soft clear", start_req, 0);

    // R3 + R6: 7-bit write waits for free bus
    set_cfg(0, 0, 0, 10'h02A);
    p_ss = 1; ticks(5);
    chk("R3", "held while busy", cmd_valid, 0);
    bus_free = 1; ticks(12);
    chk_log("R6", '{{2'd0, 8'h00}, {2'd2, 8'h54}});
    chk("R3", "master after start", master_active, 1);
    do_stop();

    // R7 + R12: 10-bit write, config write during pending request ignored
    set_cfg(1, 0, 0, 10'h2B5);
    bus_free = 0; p_ss = 1; ticks(2);
    cfg_addr = 10'h3FF; cfg_read = 1; p_cw = 1; tick();
    bus_free = 1; ticks(16);
    chk_log("R12", '{{2'd0, 8'h00}, {2'd2, 8'hF4}, {2'd2, 8'hB5}});
    do_stop();

    // R8: full 10-bit read
    set_cfg(1, 0, 1, 10'h2B5);
    p_ss = 1; ticks(22);
    chk_log("R8", '{{2'd0, 8'h00}, {2'd2, 8'hF4}, {2'd2, 8'hB5}, {2'd1, 8'h00}, {2'd2, 8'hF5}});
    do_stop();

    // R9: header-only read
    set_cfg(1, 1, 1, 10'h1C3);
    p_ss = 1; ticks(12);
    chk_log("R9", '{{2'd0, 8'h00}, {2'd2, 8'hF3}});
    do_stop();

    // R10: NACK on first 10-bit byte retries
    set_cfg(1, 0, 0, 10'h2B5);
    nackq.push_back(1);
    p_ss = 1; ticks(24);
    chk_log("R10", '{{2'd0, 8'h00}, {2'd2, 8'hF4}, {2'd1, 8'h00}, {2'd2, 8'hF4}, {2'd2, 8'hB5}});
    chk("R10", "retry no nack end", saw_nack, 0);
    do_stop();

    // R10: 7-bit NACK ends phase
    set_cfg(0, 0, 1, 10'h011);
    nackq.push_back(1);
    p_ss = 1; ticks(12);
    chk_log("R10", '{{2'd0, 8'h00}, {2'd2, 8'h23}});
    chk("R10", "nack end seen", saw_nack, 1);
    chk("R2", "cleared after phase", start_req, 0);

    // R4: repeated start on count completion
    auto_end = 0;
    p_ss = 1; ticks(5);
    chk("R4", "waits for count", cmd_valid, 0);
    count_done = 1; ticks(10);
    count_done = 0;
    chk_log("R4", '{{2'd1, 8'h00}, {2'd2, 8'h23}});

    // R5: reload blocks launch
    reload = 1; count_done = 1;
    p_ss = 1; ticks(6);
    chk("R5", "no command", cmd_valid, 0);
    chk("R5", "request kept", start_req, 1);
    p_sc = 1; ticks(2);
    reload = 0; count_done = 0;

    // R2: arbitration loss aborts
    count_done = 1; p_ss = 1; ticks(3);
    chk("R13", "command issued", cmd_valid, 1);
    p_arb = 1; ticks(2);
    chk("R2", "arb clears", start_req, 0);
    chk("R13", "arb idles", cmd_valid, 0);
    count_done = 0; auto_end = 1; logq.delete();

    // R2: timeout aborts
    p_ss = 1; ticks(3);
    p_to = 1; ticks(2);
    chk("R2", "timeout clears", start_req, 0);
    chk("R3", "timeout drops master", master_active, 0);
    logq.delete();

    // R11 + R13: enable low clears everything
    bus_free = 0;
    p_ss = 1; p_st = 1; tick();
    enable = 0; ticks(2);
    chk("R11", "enable low stop", stop_req, 0);
    chk("R2", "enable low start", start_req, 0);
    chk("R13", "enable low idle", cmd_valid, 0);
    enable = 1; bus_free = 1; ticks(3);

    report();
  end
endmodule